// File: doc/BRIEF.md
# Multi-Mode Servo Feedback Generator

This block produces the next first-stage feedback word for each detector row and writes it into one bank of a two-bank feedback RAM. The other bank is the one being read for output. A two-bit servo mode picks the source of the word. It can be zero, a programmed constant, a triangular ramp that advances on frame boundaries, or a PID servo. The PID servo combines the row's stored co-added state with per-row gain coefficients.

Upstream logic co-adds samples for one row at a time. When that row's sum is complete, it raises a per-row ready strobe. By that time sampling has already moved on to the next row. The block therefore always works on the row that has just finished, which is one row behind the row now being sampled. A frame strobe restarts the row numbering and swaps the feedback banks.

The control is a five-state machine:
- **IDLE** waits for the ready strobe.
- **FETCH** issues the state and coefficient read. This state is used in dynamic mode only.
- **LOAD** registers the three products.
- **SUM** adds, shifts and saturates.
- **WRITE** drives the RAM write.

The transitions are:
- IDLE→FETCH on a ready strobe in dynamic mode.
- IDLE→WRITE on a ready strobe in any other mode.
- FETCH→LOAD, LOAD→SUM and SUM→WRITE, each unconditional.
- WRITE→IDLE.

Top module: `servo_fb_gen`

## Requirements
- R1: Mode encoding is 0 = off, 1 = constant, 2 = ramp, 3 = dynamic. In mode 0 every row is written with 0.
- R2: In mode 1 every row is written with the 14-bit constant input as given.
- R3: In mode 2 the written value is the ramp level. The level moves by one toward the amplitude, and once there it turns and moves by one back toward 0, giving the sequence 0,1,…,A,A−1,…,0,1,…. The level advances once every L frame strobes, where L is the step-length input, and a step length of 0 acts as 1.
- R4: Whenever the mode changes into 2, the ramp level is reset to 0, the step count is cleared and the direction is set to rising.
- R5: In mode 3 the value is (P·value + I·integral + D·difference). The sum is arithmetically shifted right by 4 and clamped to 0..16383. All operands are signed; the state is 32 bits and the coefficients are 8 bits.
- R6: The D term is taken as zero for rows whose ready strobe comes between entry into mode 3 and the first frame strobe after that entry. The cycle of entry is included.
- R7: The n-th accepted ready strobe after a frame strobe writes row address n, counting from 0. That is the row just completed.
- R8: The write bank starts at 0 after reset and toggles on every frame strobe. The output-bank port always shows the other bank.
- R9: For modes 0–2 the one-cycle write pulse comes 1 cycle after the ready strobe is sampled. In mode 3 a one-cycle read request comes 1 cycle after the strobe, carrying the row address and the sampled newest-bank input. The write then comes 4 cycles after the strobe.
- R10: A ready strobe that arrives while a row is still in progress is ignored. It produces no write and does not advance the row address.
- R11: A ready strobe in the same cycle as a frame strobe belongs to the ending frame. It writes the row address reached before the frame strobe, into the bank that was in use before the swap.
- R12: After reset there is no write and no read request, and the output bank is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Servo mode (0 off, 1 constant, 2 ramp, 3 dynamic) |
| const_i | input | 14 | Constant feedback value |
| ramp_amp_i | input | 14 | Ramp peak level |
| ramp_len_i | input | 8 | Frames per ramp step |
| frame_i | input | 1 | Frame strobe |
| row_rdy_i | input | 1 | Co-added value of the finished row is ready |
| newest_bank_i | input | 1 | Co-added bank holding the newest state |
| st_value_i | input | 32 | Row's current co-added value (signed) |
| st_integ_i | input | 32 | Row's integral (signed) |
| st_diff_i | input | 32 | Row's difference (signed) |
| kp_i | input | 8 | Proportional gain (signed) |
| ki_i | input | 8 | Integral gain (signed) |
| kd_i | input | 8 | Derivative gain (signed) |
| st_rd_en_o | output | 1 | State and coefficient read request |
| st_rd_addr_o | output | 3 | Row address of the read |
| st_rd_bank_o | output | 1 | Co-added bank to read |
| fb_we_o | output | 1 | Feedback RAM write enable |
| fb_addr_o | output | 3 | Feedback RAM row address |
| fb_bank_o | output | 1 | Feedback RAM bank written |
| fb_data_o | output | 14 | Feedback value written |
| out_bank_o | output | 1 | Bank currently read for output |

## Verification
The frame strobe and a row-ready strobe can land in the same clock cycle. The frame strobe resets the row count and swaps banks, while the ready strobe captures the row count and bank for its write. The bench raises both strobes on one edge. It then checks that the write carries the old row address and the old bank, and that the next row starts at address 0 in the new bank. A second overlap is a ready strobe arriving while a dynamic-mode row is still in the pipeline. The bench judges this by counting write pulses and checking the row address of the next accepted row.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_CONST = 2'd1,
        MODE_RAMP  = 2'd2,
        MODE_PID   = 2'd3
    } servo_mode_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_LOAD  = 3'd2,
        S_SUM   = 3'd3,
        S_WRITE = 3'd4
    } calc_state_e;

endpackage

// File: rtl/fbg_ramp.sv
module fbg_ramp
    import fbg_pkg::*;
#(
    parameter int DAC_W = 14,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  servo_mode_e      mode_i,
    input  logic             frame_i,
    input  logic [DAC_W-1:0] amp_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [DAC_W-1:0] level_o
);

    servo_mode_e      prev_mode_q;
    logic [DAC_W-1:0] level_q;
    logic             rising_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_eff;
    logic             entry;
    logic             step_due;

    assign entry    = (mode_i == MODE_RAMP) && (prev_mode_q != MODE_RAMP);
    assign len_eff  = (len_i == '0) ? LEN_W'(1) : len_i;
    assign step_due = ({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, len_eff};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_mode_q <= MODE_OFF;
            level_q     <= '0;
            rising_q    <= 1'b1;
            cnt_q       <= '0;
        end else begin
            prev_mode_q <= mode_i;
            if (entry) begin
                level_q  <= '0;
                rising_q <= 1'b1;
                cnt_q    <= '0;
            end else if (mode_i == MODE_RAMP && frame_i) begin
                if (step_due) begin
                    cnt_q <= '0;
                    if (rising_q) begin
                        if (level_q < amp_i) begin
                            level_q <= level_q + 1'b1;
                        end else begin
                            rising_q <= 1'b0;
                            level_q  <= (level_q != '0) ? level_q - 1'b1 : '0;
                        end
                    end else begin
                        if (level_q != '0) begin
                            level_q <= level_q - 1'b1;
                        end else begin
                            rising_q <= 1'b1;
                            level_q  <= (amp_i != '0) ? DAC_W'(1) : '0;
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign level_o = level_q;

    AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> (level_q == $past(level_q) + 1'b1) ||
                              (level_q == $past(level_q) - 1'b1) ||
                              (level_q == '0)); // R3
    AST_RAMP_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (level_o == '0)); // R4

endmodule

// File: rtl/fbg_pid.sv
module fbg_pid #(
    parameter int DAT_W = 32,
    parameter int COEF_W = 8,
    parameter int DAC_W = 14,
    parameter int SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_prod_i,
    input  logic                     load_sum_i,
    input  logic                     d_zero_i,
    input  logic signed [DAT_W-1:0]  value_i,
    input  logic signed [DAT_W-1:0]  integ_i,
    input  logic signed [DAT_W-1:0]  diff_i,
    input  logic signed [COEF_W-1:0] kp_i,
    input  logic signed [COEF_W-1:0] ki_i,
    input  logic signed [COEF_W-1:0] kd_i,
    output logic [DAC_W-1:0]         result_o
);

    localparam int PROD_W = DAT_W + COEF_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'd1 << DAC_W) - 64'd1);

    logic signed [PROD_W-1:0] pp_q, pi_q, pd_q;
    logic signed [SUM_W-1:0]  total;
    logic signed [SUM_W-1:0]  scaled;
    logic [DAC_W-1:0]         res_q;

    always_comb begin
        total  = SUM_W'(pp_q) + SUM_W'(pi_q) + SUM_W'(pd_q);
        scaled = total >>> SHIFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q  <= '0;
            pi_q  <= '0;
            pd_q  <= '0;
            res_q <= '0;
        end else begin
            if (load_prod_i) begin
                pp_q <= PROD_W'(value_i) * PROD_W'(kp_i);
                pi_q <= PROD_W'(integ_i) * PROD_W'(ki_i);
                pd_q <= d_zero_i ? '0 : PROD_W'(diff_i) * PROD_W'(kd_i);
            end
            if (load_sum_i) begin
                if (scaled < 0) begin
                    res_q <= '0;
                end else if (scaled > SAT_HI) begin
                    res_q <= {DAC_W{1'b1}};
                end else begin
                    res_q <= scaled[DAC_W-1:0];
                end
            end
        end
    end

    assign result_o = res_q;

    AST_D_TERM_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_prod_i && d_zero_i) |=> (pd_q == '0)); // R6

endmodule

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
    import fbg_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int DAC_W = 14,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  servo_mode_e      mode_i,
    input  logic             frame_i,
    input  logic             row_rdy_i,
    input  logic             newest_bank_i,
    input  logic [DAC_W-1:0] const_i,
    input  logic [DAC_W-1:0] ramp_level_i,
    input  logic [DAC_W-1:0] pid_result_i,
    output logic             rd_en_o,
    output logic [ROW_W-1:0] rd_addr_o,
    output logic             rd_bank_o,
    output logic             load_prod_o,
    output logic             load_sum_o,
    output logic             d_zero_o,
    output logic             we_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             bank_o,
    output logic [DAC_W-1:0] data_o,
    output logic             out_bank_o
);

    calc_state_e      state_q, state_d;
    servo_mode_e      prev_mode_q;
    logic [ROW_W-1:0] row_cnt_q;
    logic [ROW_W-1:0] row_q;
    logic             wr_bank_q;
    logic             bank_q;
    logic             nbank_q;
    logic             dz_flag_q;
    logic             dz_q;
    logic             dyn_q;
    logic [DAC_W-1:0] data_q;
    logic             accept;
    logic             pid_entry;

    assign accept    = (state_q == S_IDLE) && row_rdy_i;
    assign pid_entry = (mode_i == MODE_PID) && (prev_mode_q != MODE_PID);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (row_rdy_i) state_d = (mode_i == MODE_PID) ? S_FETCH : S_WRITE;
            S_FETCH: state_d = S_LOAD;
            S_LOAD:  state_d = S_SUM;
            S_SUM:   state_d = S_WRITE;
            S_WRITE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // row tracking, bank swap, D-term gating and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_mode_q <= MODE_OFF;
            row_cnt_q   <= '0;
            row_q       <= '0;
            wr_bank_q   <= 1'b0;
            bank_q      <= 1'b0;
            nbank_q     <= 1'b0;
            dz_flag_q   <= 1'b0;
            dz_q        <= 1'b0;
            dyn_q       <= 1'b0;
            data_q      <= '0;
        end else begin
            prev_mode_q <= mode_i;
            if (frame_i) wr_bank_q <= ~wr_bank_q;
            if (pid_entry)    dz_flag_q <= 1'b1;
            else if (frame_i) dz_flag_q <= 1'b0;
            if (frame_i) begin
                row_cnt_q <= '0;
            end else if (accept) begin
                row_cnt_q <= (row_cnt_q == ROW_W'(ROWS-1)) ? '0 : row_cnt_q + 1'b1;
            end
            if (accept) begin
                row_q   <= row_cnt_q;
                bank_q  <= wr_bank_q;
                nbank_q <= newest_bank_i;
                dz_q    <= dz_flag_q | pid_entry;
                dyn_q   <= (mode_i == MODE_PID);
                unique case (mode_i)
                    MODE_OFF:   data_q <= '0;
                    MODE_CONST: data_q <= const_i;
                    MODE_RAMP:  data_q <= ramp_level_i;
                    MODE_PID:   data_q <= '0;
                    default:    data_q <= '0;
                endcase
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        rd_en_o     = (state_q == S_FETCH);
        load_prod_o = (state_q == S_LOAD);
        load_sum_o  = (state_q == S_SUM);
        we_o        = (state_q == S_WRITE);
        rd_addr_o   = row_q;
        rd_bank_o   = nbank_q;
        addr_o      = row_q;
        bank_o      = bank_q;
        d_zero_o    = dz_q;
        data_o      = dyn_q ? pid_result_i : data_q;
        out_bank_o  = ~wr_bank_q;
    end

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o); // R9
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> ##2 we_o); // R9
    AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (out_bank_o != $past(out_bank_o))); // R8
    AST_DZ_ENDS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dz_flag_q) |-> $past(frame_i)); // R6
    AST_BUSY_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && row_rdy_i && !frame_i) |=> $stable(row_cnt_q)); // R10

endmodule

// File: rtl/servo_fb_gen.sv
module servo_fb_gen
    import fbg_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int DAC_W = 14,
    parameter int LEN_W = 8,
    parameter int DAT_W = 32,
    parameter int COEF_W = 8,
    parameter int SHIFT = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic [DAC_W-1:0]         const_i,
    input  logic [DAC_W-1:0]         ramp_amp_i,
    input  logic [LEN_W-1:0]         ramp_len_i,
    input  logic                     frame_i,
    input  logic                     row_rdy_i,
    input  logic                     newest_bank_i,
    input  logic signed [DAT_W-1:0]  st_value_i,
    input  logic signed [DAT_W-1:0]  st_integ_i,
    input  logic signed [DAT_W-1:0]  st_diff_i,
    input  logic signed [COEF_W-1:0] kp_i,
    input  logic signed [COEF_W-1:0] ki_i,
    input  logic signed [COEF_W-1:0] kd_i,
    output logic                     st_rd_en_o,
    output logic [ROW_W-1:0]         st_rd_addr_o,
    output logic                     st_rd_bank_o,
    output logic                     fb_we_o,
    output logic [ROW_W-1:0]         fb_addr_o,
    output logic                     fb_bank_o,
    output logic [DAC_W-1:0]         fb_data_o,
    output logic                     out_bank_o
);

    servo_mode_e      mode;
    logic [DAC_W-1:0] ramp_level;
    logic [DAC_W-1:0] pid_result;
    logic             load_prod;
    logic             load_sum;
    logic             d_zero;

    assign mode = servo_mode_e'(mode_i);

    fbg_ramp #(.DAC_W(DAC_W), .LEN_W(LEN_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .frame_i (frame_i),
        .amp_i   (ramp_amp_i),
        .len_i   (ramp_len_i),
        .level_o (ramp_level)
    );

    fbg_pid #(.DAT_W(DAT_W), .COEF_W(COEF_W), .DAC_W(DAC_W), .SHIFT(SHIFT)) u_pid (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_prod_i (load_prod),
        .load_sum_i  (load_sum),
        .d_zero_i    (d_zero),
        .value_i     (st_value_i),
        .integ_i     (st_integ_i),
        .diff_i      (st_diff_i),
        .kp_i        (kp_i),
        .ki_i        (ki_i),
        .kd_i        (kd_i),
        .result_o    (pid_result)
    );

    fbg_ctrl #(.ROWS(ROWS), .DAC_W(DAC_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .frame_i       (frame_i),
        .row_rdy_i     (row_rdy_i),
        .newest_bank_i (newest_bank_i),
        .const_i       (const_i),
        .ramp_level_i  (ramp_level),
        .pid_result_i  (pid_result),
        .rd_en_o       (st_rd_en_o),
        .rd_addr_o     (st_rd_addr_o),
        .rd_bank_o     (st_rd_bank_o),
        .load_prod_o   (load_prod),
        .load_sum_o    (load_sum),
        .d_zero_o      (d_zero),
        .we_o          (fb_we_o),
        .addr_o        (fb_addr_o),
        .bank_o        (fb_bank_o),
        .data_o        (fb_data_o),
        .out_bank_o    (out_bank_o)
    );

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we_o |-> (int'(fb_addr_o) < ROWS)); // R7

endmodule

// File: tb/sim_servo_fb_gen.sv
`timescale 1ns/1ps
module sim_servo_fb_gen;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_i = 2'd0;
    logic [13:0]       const_i = '0;
    logic [13:0]       ramp_amp_i = '0;
    logic [7:0]        ramp_len_i = '0;
    logic              frame_i = 1'b0;
    logic              row_rdy_i = 1'b0;
    logic              newest_bank_i = 1'b1;
    logic signed [31:0] st_value_i = '0;
    logic signed [31:0] st_integ_i = '0;
    logic signed [31:0] st_diff_i = '0;
    logic signed [7:0]  kp_i = '0;
    logic signed [7:0]  ki_i = '0;
    logic signed [7:0]  kd_i = '0;
    logic              st_rd_en_o;
    logic [2:0]        st_rd_addr_o;
    logic              st_rd_bank_o;
    logic              fb_we_o;
    logic [2:0]        fb_addr_o;
    logic              fb_bank_o;
    logic [13:0]       fb_data_o;
    logic              out_bank_o;

    always #2.5 clk = ~clk;

    servo_fb_gen u0 (.*);

    int checks = 0;
    int fails  = 0;
    int exp_row = 0;
    int exp_bank = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        frm;
        logic [1:0]  mode;
        logic [13:0] cval;
        logic [31:0] v;
        logic [31:0] it;
        logic [31:0] df;
        logic [7:0]  p;
        logic [7:0]  i;
        logic [7:0]  d;
        logic [13:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 2'd0, 14'h1234, 32'd0, 32'd0, 32'd0, 8'd0, 8'd0, 8'd0, 14'd0},           // R1
        '{1'b0, 2'd1, 14'h2ABC, 32'd0, 32'd0, 32'd0, 8'd0, 8'd0, 8'd0, 14'h2ABC},        // R2
        '{1'b0, 2'd1, 14'h3FFF, 32'd0, 32'd0, 32'd0, 8'd0, 8'd0, 8'd0, 14'h3FFF},        // R2
        '{1'b0, 2'd3, 14'h0, 32'd100, 32'd50, 32'd30, 8'd2, 8'd1, 8'd5, 14'd15},         // R6 D muted
        '{1'b1, 2'd3, 14'h0, 32'd100, 32'd50, 32'd30, 8'd2, 8'd1, 8'd5, 14'd25},         // R5
        '{1'b0, 2'd3, 14'h0, 32'hFFFFFC18, 32'd0, 32'd0, 8'd1, 8'd0, 8'd0, 14'd0},       // R5 low clamp
        '{1'b0, 2'd3, 14'h0, 32'd100000, 32'd0, 32'd0, 8'd10, 8'd0, 8'd0, 14'h3FFF},     // R5 high clamp
        '{1'b0, 2'd3, 14'h0, 32'd0, 32'hFFFFFFE0, 32'd64, 8'd0, 8'd1, 8'd1, 14'd2}       // R5 signed
    };

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic frame_pulse();
        frame_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0;
        exp_row = 0;
        exp_bank ^= 1;
        chk(out_bank_o == ~exp_bank[0], "R8 output bank", int'(out_bank_o), 1 - exp_bank);
    endtask

    // pulse ready, wait for write, check latency, data, address, bank
    task automatic do_row(input int expd, input int exp_lat, input string req);
        int lat;
        row_rdy_i = 1'b1;
        @(negedge clk);
        row_rdy_i = 1'b0;
        lat = 1;
        if (exp_lat > 1) begin
            chk(st_rd_en_o && st_rd_addr_o == exp_row[2:0] && st_rd_bank_o == newest_bank_i,
                "R9 read request", int'(st_rd_addr_o), exp_row);
        end
        while (!fb_we_o && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R9 latency", lat, exp_lat);
        chk(fb_data_o == expd[13:0], req, int'(fb_data_o), expd);
        chk(fb_addr_o == exp_row[2:0] && fb_bank_o == exp_bank[0], "R7 R8 address/bank",
            int'(fb_addr_o) * 2 + int'(fb_bank_o), exp_row * 2 + exp_bank);
        exp_row = (exp_row + 1) % 8;
        @(negedge clk);
    endtask

    function automatic int tri2(input int k);
        int m = k % 4;
        return (m == 3) ? 1 : m;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin : stim
        int nwe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fb_we_o && !st_rd_en_o && out_bank_o, "R12 reset state",
            int'({fb_we_o, st_rd_en_o, out_bank_o}), 1);

        // table walk
        for (int n = 0; n < 8; n++) begin
            if (VEC[n].frm) frame_pulse();
            mode_i     = VEC[n].mode;
            const_i    = VEC[n].cval;
            st_value_i = $signed(VEC[n].v);
            st_integ_i = $signed(VEC[n].it);
            st_diff_i  = $signed(VEC[n].df);
            kp_i       = $signed(VEC[n].p);
            ki_i       = $signed(VEC[n].i);
            kd_i       = $signed(VEC[n].d);
            do_row(int'(VEC[n].exp), (VEC[n].mode == 2'd3) ? 4 : 1, "R1 R2 R5 R6 table value");
        end

        // R10: second ready while a dynamic row is busy
        st_value_i = 32'sd160; kp_i = 8'sd1; ki_i = 8'sd0; kd_i = 8'sd0;
        row_rdy_i = 1'b1;
        @(negedge clk);
        nwe = 0;
        @(negedge clk);
        row_rdy_i = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (fb_we_o) begin
                nwe++;
                chk(fb_addr_o == exp_row[2:0] && fb_data_o == 14'd10, "R10 busy write",
                    int'(fb_addr_o), exp_row);
            end
            @(negedge clk);
        end
        chk(nwe == 1, "R10 single write", nwe, 1);
        exp_row++;
        do_row(10, 4, "R10 next row value");

        // R3 ramp with amplitude 2, step length 2
        ramp_amp_i = 14'd2; ramp_len_i = 8'd2; mode_i = 2'd2;
        @(negedge clk);
        do_row(0, 1, "R4 ramp starts at zero");
        for (int j = 1; j <= 10; j++) begin
            frame_pulse();
            do_row(tri2(j / 2), 1, "R3 ramp level");
        end
        // R4 re-entry resets
        mode_i = 2'd1;
        @(negedge clk);
        mode_i = 2'd2;
        @(negedge clk);
        do_row(0, 1, "R4 re-entry reset");
        // R3 step length 0 acts as 1
        ramp_len_i = 8'd0;
        frame_pulse();
        do_row(1, 1, "R3 len0 step");
        frame_pulse();
        do_row(2, 1, "R3 len0 apex");
        frame_pulse();
        do_row(1, 1, "R3 len0 descend");

        // R11 coincident frame and ready
        mode_i = 2'd1; const_i = 14'h0155;
        @(negedge clk);
        frame_i = 1'b1; row_rdy_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0; row_rdy_i = 1'b0;
        chk(fb_we_o && fb_addr_o == exp_row[2:0] && fb_bank_o == exp_bank[0],
            "R11 old row and bank", int'(fb_addr_o) * 2 + int'(fb_bank_o), exp_row * 2 + exp_bank);
        chk(fb_data_o == 14'h0155, "R11 data", int'(fb_data_o), 14'h0155);
        exp_row = 0;
        exp_bank ^= 1;
        @(negedge clk);
        do_row(14'h0155, 1, "R11 next frame row");

        // R1 back to off
        mode_i = 2'd0;
        do_row(0, 1, "R1 off after const");

        finish_run();
    end

endmodule